// File: doc/BRIEF.md
# Dual-Channel Timer Bus Front End

This block is the register-bus front end for a pair of timer channels. It sits on an APB-style peripheral bus and owns a 4 KB window. Offsets below 0xF00 are steered to the channel register slots. The block sends a write strobe, the in-channel offset and the write data to the selected channel. For reads it returns that channel's read data. The counting logic of the channels lives elsewhere. This block only routes accesses to them and gathers their masked interrupt status.

Above the channel range the block holds its own small register set. A test-control register switches the interrupt outputs into a software-driven test mode. A write-only test-output register supplies the interrupt levels while that mode is active. A bank of twelve read-only identification bytes sits at the top of the window. Each channel has its own registered interrupt output, and a further registered output is the OR of the per-channel ones. Every access finishes in its access phase with no wait states.

Top module: `dtb_bus`

## Requirements
- R1: Every access completes in its access phase: `pready_o` is 1 and `pslverr_o` is 0 at all times.
- R2: For an offset below 0xF00, offset bits [11:5] select the channel (0 selects channel 0 and 1 selects channel 1). Bits [4:0] are presented on `ch_addr_o`, and `pwdata_i` is presented on `ch_wdata_o`. A write strobe goes to the addressed channel only, and only in the access phase of a write.
- R3: Within a channel, writes are forwarded only to slots 0x00, 0x08, 0x0C and 0x18. Reads return the channel's data only for slots 0x00, 0x04, 0x08, 0x10, 0x14 and 0x18. Any other slot reads as zero and raises no strobe (for example 0x0C on a read, and 0x1C).
- R4: A channel index of 2 or higher below 0xF00 (offsets 0x040 to 0xEFC) is unmapped. It reads as zero and strobes no channel.
- R5: The test-control register is at 0xF00. Bit 0 enables test mode and reads back, and all other bits read as zero.
- R6: The test-output register is at 0xF04. Bit 0 is for channel 0 and bit 1 is for channel 1. It is write-only and reads as zero.
- R7: When test mode is on, `irq_o[i]` takes test-output bit i one clock after the register state changes, whatever the value of `ch_mis_i`.
- R8: When test mode is off, `irq_o[i]` equals `ch_mis_i[i]` delayed by exactly one clock.
- R9: `irq_comb_o` is the OR of the two bits of `irq_o` in every cycle.
- R10: Offsets 0xFD0 to 0xFFC, one per word, read in address order as the bytes 04, 00, 00, 00, 23, B8, 1B, 00, 0D, F0, 05, B1, zero-extended to 32 bits. Writes to them have no effect.
- R11: Every other offset at or above 0xF00 (for example 0xF08 or 0xFCC) reads as zero, and a write to it leaves the test registers unchanged.
- R12: Reset clears the test-control register, the test-output register and all interrupt outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | Peripheral select |
| penable_i | input | 1 | Access-phase indicator |
| pwrite_i | input | 1 | 1 for write, 0 for read |
| paddr_i | input | 12 | Byte offset within the window |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data, valid in the read access phase |
| pready_o | output | 1 | Always ready |
| pslverr_o | output | 1 | Always zero |
| ch_wen_o | output | 2 | Per-channel write strobe |
| ch_ren_o | output | 2 | Per-channel read strobe |
| ch_addr_o | output | 5 | Register offset within the channel |
| ch_wdata_o | output | 32 | Write data forwarded to the channels |
| ch_rdata_i | input | 64 | Channel read data, channel 1 in bits [63:32] |
| ch_mis_i | input | 2 | Masked interrupt status from each channel |
| irq_o | output | 2 | Per-channel interrupt outputs |
| irq_comb_o | output | 1 | OR of both interrupt outputs |

## Verification
The properties assume a well-formed bus. A setup phase with `psel_i` high and `penable_i` low comes before each access phase, and the address and direction stay stable across the two phases. The one-cycle tracking property for the normal-mode interrupts also assumes that `ch_mis_i` changes only between clock edges. The stimulus tasks build every transfer as a setup phase followed by an access phase, with all signals driven on falling edges. The bench changes the channel status only on falling edges, and always while no transfer is in flight.

// File: rtl/dtb_pkg.sv
package dtb_pkg;
  localparam logic [4:0] SLOT_LOAD = 5'h00;
  localparam logic [4:0] SLOT_CNT  = 5'h04;
  localparam logic [4:0] SLOT_CTRL = 5'h08;
  localparam logic [4:0] SLOT_ACK  = 5'h0C;
  localparam logic [4:0] SLOT_RAW  = 5'h10;
  localparam logic [4:0] SLOT_MSK  = 5'h14;
  localparam logic [4:0] SLOT_BGL  = 5'h18;

  localparam logic [11:0] OFS_TEST_CTL = 12'hF00;
  localparam logic [11:0] OFS_TEST_OUT = 12'hF04;

  function automatic logic slot_wr_ok(logic [4:0] s);
    return (s == SLOT_LOAD) || (s == SLOT_CTRL) || (s == SLOT_ACK) || (s == SLOT_BGL);
  endfunction

  function automatic logic slot_rd_ok(logic [4:0] s);
    return (s == SLOT_LOAD) || (s == SLOT_CNT) || (s == SLOT_CTRL) ||
           (s == SLOT_RAW)  || (s == SLOT_MSK) || (s == SLOT_BGL);
  endfunction

  // identification bytes, index 0 at 0xFD0
  function automatic logic [7:0] ident_byte(logic [3:0] idx);
    case (idx)
      4'd0:    return 8'h04;
      4'd4:    return 8'h23;
      4'd5:    return 8'hB8;
      4'd6:    return 8'h1B;
      4'd8:    return 8'h0D;
      4'd9:    return 8'hF0;
      4'd10:   return 8'h05;
      4'd11:   return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/dtb_decode.sv
module dtb_decode #(
  parameter int NCH = 2,
  parameter int AW  = 12
) (
  input  logic [AW-1:0]  addr_i,
  output logic [NCH-1:0] ch_hit_o,
  output logic           wr_ok_o,
  output logic           rd_ok_o,
  output logic           tctl_hit_o,
  output logic           tout_hit_o,
  output logic           id_hit_o,
  output logic [3:0]     id_idx_o
);
  import dtb_pkg::*;
  localparam int IW = AW - 5;

  logic          below_test;
  logic [IW-1:0] ch_idx;

  assign below_test = addr_i < AW'(OFS_TEST_CTL);
  assign ch_idx     = addr_i[AW-1:5];
  assign wr_ok_o    = slot_wr_ok(addr_i[4:0]);
  assign rd_ok_o    = slot_rd_ok(addr_i[4:0]);

  for (genvar c = 0; c < NCH; c++) begin : g_hit
    assign ch_hit_o[c] = below_test && (ch_idx == IW'(c));
  end

  assign tctl_hit_o = addr_i == AW'(OFS_TEST_CTL);
  assign tout_hit_o = addr_i == AW'(OFS_TEST_OUT);
  // 0xFD0..0xFFC: top six bits all ones, bits [5:4] nonzero
  assign id_hit_o   = (addr_i[AW-1:6] == '1) && (addr_i[5:4] != 2'b00);
  assign id_idx_o   = addr_i[5:2] - 4'd4;
endmodule

// File: rtl/dtb_test_ctl.sv
module dtb_test_ctl #(
  parameter int NCH = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tctl_we_i,
  input  logic           tout_we_i,
  input  logic [NCH-1:0] wdata_i,
  input  logic [NCH-1:0] ch_mis_i,
  output logic           test_en_o,
  output logic [NCH-1:0] irq_o,
  output logic           irq_comb_o
);
  logic [NCH-1:0] tout_q;
  logic [NCH-1:0] irq_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      test_en_o <= 1'b0;
      tout_q    <= '0;
    end else begin
      if (tctl_we_i) test_en_o <= wdata_i[0];
      if (tout_we_i) tout_q    <= wdata_i;
    end
  end

  assign irq_d = test_en_o ? tout_q : ch_mis_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o      <= '0;
      irq_comb_o <= 1'b0;
    end else begin
      irq_o      <= irq_d;
      irq_comb_o <= |irq_d;
    end
  end
endmodule

// File: rtl/dtb_bus.sv
module dtb_bus #(
  parameter int NCH = 2,
  parameter int AW  = 12,
  parameter int DW  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             psel_i,
  input  logic             penable_i,
  input  logic             pwrite_i,
  input  logic [AW-1:0]    paddr_i,
  input  logic [DW-1:0]    pwdata_i,
  output logic [DW-1:0]    prdata_o,
  output logic             pready_o,
  output logic             pslverr_o,
  output logic [NCH-1:0]   ch_wen_o,
  output logic [NCH-1:0]   ch_ren_o,
  output logic [4:0]       ch_addr_o,
  output logic [DW-1:0]    ch_wdata_o,
  input  logic [NCH*DW-1:0] ch_rdata_i,
  input  logic [NCH-1:0]   ch_mis_i,
  output logic [NCH-1:0]   irq_o,
  output logic             irq_comb_o
);
  import dtb_pkg::*;

  logic           acc_wr, acc_rd;
  logic [NCH-1:0] ch_hit;
  logic           wr_ok, rd_ok, tctl_hit, tout_hit, id_hit;
  logic [3:0]     id_idx;
  logic           test_en;
  logic [DW-1:0]  ch_rd_sel [NCH];
  logic [DW-1:0]  ch_rd_or;

  assign acc_wr = psel_i && penable_i && pwrite_i;
  assign acc_rd = psel_i && penable_i && !pwrite_i;

  dtb_decode #(.NCH(NCH), .AW(AW)) u_dec (
    .addr_i     (paddr_i),
    .ch_hit_o   (ch_hit),
    .wr_ok_o    (wr_ok),
    .rd_ok_o    (rd_ok),
    .tctl_hit_o (tctl_hit),
    .tout_hit_o (tout_hit),
    .id_hit_o   (id_hit),
    .id_idx_o   (id_idx)
  );

  assign ch_addr_o  = paddr_i[4:0];
  assign ch_wdata_o = pwdata_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ch_wen_o[c]  = acc_wr && ch_hit[c] && wr_ok;
    assign ch_ren_o[c]  = acc_rd && ch_hit[c] && rd_ok;
    assign ch_rd_sel[c] = (ch_hit[c] && rd_ok) ? ch_rdata_i[c*DW +: DW] : '0;
  end

  always_comb begin
    ch_rd_or = '0;
    for (int c = 0; c < NCH; c++) ch_rd_or |= ch_rd_sel[c];
  end

  always_comb begin
    prdata_o = '0;
    if (acc_rd) begin
      if (|ch_hit)       prdata_o = ch_rd_or;
      else if (tctl_hit) prdata_o = DW'(test_en);
      else if (id_hit)   prdata_o = DW'(ident_byte(id_idx));
    end
  end

  dtb_test_ctl #(.NCH(NCH)) u_tst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tctl_we_i  (acc_wr && tctl_hit),
    .tout_we_i  (acc_wr && tout_hit),
    .wdata_i    (pwdata_i[NCH-1:0]),
    .ch_mis_i   (ch_mis_i),
    .test_en_o  (test_en),
    .irq_o      (irq_o),
    .irq_comb_o (irq_comb_o)
  );

  assign pready_o  = 1'b1;
  assign pslverr_o = 1'b0;
endmodule

// File: rtl/dtb_bus_chk.sv
module dtb_bus_chk #(
  parameter int NCH = 2,
  parameter int AW  = 12,
  parameter int DW  = 32
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           psel_i,
  input logic           penable_i,
  input logic           pwrite_i,
  input logic [AW-1:0]  paddr_i,
  input logic [DW-1:0]  prdata_o,
  input logic [NCH-1:0] ch_wen_o,
  input logic [NCH-1:0] ch_ren_o,
  input logic [NCH-1:0] ch_mis_i,
  input logic [NCH-1:0] irq_o,
  input logic           irq_comb_o,
  input logic           test_en
);
  logic past_ok;
  logic rd_acc, chan_area;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assign rd_acc    = psel_i && penable_i && !pwrite_i;
  assign chan_area = paddr_i < AW'(12'hF00);

  AST_WEN_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_wen_o)); // R2
  AST_WEN_IN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ch_wen_o) |-> (psel_i && penable_i && pwrite_i)); // R2
  AST_ACK_SLOT_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && chan_area && paddr_i[4:0] == 5'h0C) |-> (prdata_o == '0 && ch_ren_o == '0)); // R3
  AST_HIGH_CH_UNMAPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && chan_area && (int'(paddr_i[AW-1:5]) >= NCH)) |-> (ch_wen_o == '0 && ch_ren_o == '0)); // R4
  AST_TOUT_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && paddr_i == AW'(12'hF04)) |-> prdata_o == '0); // R6
  AST_IRQ_TRACKS_MIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(test_en)) |-> irq_o == $past(ch_mis_i)); // R8
  AST_COMB_IS_OR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_comb_o == (|irq_o)); // R9
  AST_IDENT_FE0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && paddr_i == AW'(12'hFE0)) |-> prdata_o == DW'(8'h23)); // R10
endmodule

bind dtb_bus dtb_bus_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .psel_i     (psel_i),
  .penable_i  (penable_i),
  .pwrite_i   (pwrite_i),
  .paddr_i    (paddr_i),
  .prdata_o   (prdata_o),
  .ch_wen_o   (ch_wen_o),
  .ch_ren_o   (ch_ren_o),
  .ch_mis_i   (ch_mis_i),
  .irq_o      (irq_o),
  .irq_comb_o (irq_comb_o),
  .test_en    (test_en)
);

// File: tb/sim_dtb_bus.sv
`timescale 1ns/1ps
module sim_dtb_bus;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [1:0]  ch_wen, ch_ren, ch_mis = 2'b00, irq;
  logic [4:0]  ch_addr;
  logic [31:0] ch_wdata;
  logic [63:0] ch_rdata;
  logic        irq_comb;

  int checks = 0;
  int fails  = 0;
  logic [1:0]  cap_wen;
  logic [4:0]  cap_addr;
  logic [31:0] cap_wdata;

  always #5 clk = ~clk;

  // channel models: read data tags the channel and echoes the slot
  assign ch_rdata = {8'hB1, 19'd0, ch_addr, 8'hA0, 19'd0, ch_addr};

  dtb_bus u0 (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata), .pready_o(pready),
    .pslverr_o(pslverr), .ch_wen_o(ch_wen), .ch_ren_o(ch_ren), .ch_addr_o(ch_addr),
    .ch_wdata_o(ch_wdata), .ch_rdata_i(ch_rdata), .ch_mis_i(ch_mis), .irq_o(irq),
    .irq_comb_o(irq_comb)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb(input logic wr, input logic [11:0] a, input logic [31:0] d,
                     output logic [31:0] rd);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    #1;
    rd = prdata; cap_wen = ch_wen; cap_addr = ch_addr; cap_wdata = ch_wdata;
    chk("R1 ready/no-error", {30'd0, pready, pslverr}, 32'h2);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  localparam int NV = 25;
  localparam logic [11:0] V_ADDR [NV] = '{
    12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'h014, 12'h018, 12'h01C,
    12'h020, 12'h034, 12'h03C, 12'h040, 12'hEFC, 12'hF00, 12'hF04, 12'hF08,
    12'hFD0, 12'hFE0, 12'hFE4, 12'hFE8, 12'hFF0, 12'hFF4, 12'hFF8, 12'hFFC,
    12'hFCC};
  localparam logic [31:0] V_EXP [NV] = '{
    32'hA0000000, 32'hA0000004, 32'hA0000008, 32'h0, 32'hA0000010, 32'hA0000014,
    32'hA0000018, 32'h0, 32'hB1000000, 32'hB1000014, 32'h0, 32'h0, 32'h0,
    32'h0, 32'h0, 32'h0,
    32'h04, 32'h23, 32'hB8, 32'h1B, 32'h0D, 32'hF0, 32'h05, 32'hB1, 32'h0};
  // requirement tags: R2/R3 channel slots, R4 high index, R5 R6 R11 test area, R10 ident
  localparam int V_REQ [NV] = '{2,2,2,3,2,2,2,3,2,2,3,4,4,5,6,11,10,10,10,10,10,10,10,10,11};

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    #1;
    chk("R12 irq after reset", {30'd0, irq}, 32'h0);
    chk("R12 comb after reset", {31'd0, irq_comb}, 32'h0);
    rst_n = 1'b1;
    settle();

    for (int i = 0; i < NV; i++) begin
      apb(1'b0, V_ADDR[i], 32'h0, r);
      chk($sformatf("R%0d read %h", V_REQ[i], V_ADDR[i]), r, V_EXP[i]);
    end

    // write routing, R2 and R3
    apb(1'b1, 12'h008, 32'hCAFE0011, r);
    chk("R2 wen ch0 ctrl", {30'd0, cap_wen}, 32'h1);
    chk("R2 ch_addr", {27'd0, cap_addr}, 32'h08);
    chk("R2 ch_wdata", cap_wdata, 32'hCAFE0011);
    apb(1'b1, 12'h038, 32'h5, r);
    chk("R2 wen ch1 bgload", {30'd0, cap_wen}, 32'h2);
    apb(1'b1, 12'h02C, 32'h0, r);
    chk("R3 wen ch1 ack", {30'd0, cap_wen}, 32'h2);
    apb(1'b1, 12'h004, 32'h1, r);
    chk("R3 count slot not writable", {30'd0, cap_wen}, 32'h0);
    apb(1'b1, 12'h014, 32'h1, r);
    chk("R3 masked slot not writable", {30'd0, cap_wen}, 32'h0);
    apb(1'b1, 12'h04C, 32'h1, r);
    chk("R4 high channel write", {30'd0, cap_wen}, 32'h0);

    // normal mode tracking, R8 and R9
    @(negedge clk); ch_mis = 2'b01; #1;
    chk("R8 not yet visible", {30'd0, irq}, 32'h0);
    settle();
    chk("R8 irq ch0", {30'd0, irq}, 32'h1);
    chk("R9 comb ch0", {31'd0, irq_comb}, 32'h1);
    ch_mis = 2'b10;
    settle();
    chk("R8 irq ch1", {30'd0, irq}, 32'h2);
    chk("R9 comb ch1", {31'd0, irq_comb}, 32'h1);
    ch_mis = 2'b00;
    settle();
    chk("R9 comb idle", {31'd0, irq_comb}, 32'h0);

    // test mode, R5 R6 R7
    apb(1'b1, 12'hF04, 32'h3, r);
    settle();
    chk("R7 test bits ignored when off", {30'd0, irq}, 32'h0);
    apb(1'b1, 12'hF00, 32'h1, r);
    settle();
    chk("R7 test drive 11", {30'd0, irq}, 32'h3);
    apb(1'b0, 12'hF00, 32'h0, r);
    chk("R5 test ctl reads 1", r, 32'h1);
    apb(1'b0, 12'hF04, 32'h0, r);
    chk("R6 test out reads 0", r, 32'h0);
    ch_mis = 2'b01;
    settle();
    chk("R7 mis ignored in test mode", {30'd0, irq}, 32'h3);
    apb(1'b1, 12'hF04, 32'h2, r);
    settle();
    chk("R7 test drive 10", {30'd0, irq}, 32'h2);
    apb(1'b1, 12'hF04, 32'h0, r);
    settle();
    chk("R7 test drive 00", {30'd0, irq}, 32'h0);
    chk("R9 comb in test", {31'd0, irq_comb}, 32'h0);

    // R11: writes outside the map leave test state alone
    apb(1'b1, 12'hF08, 32'h0, r);
    apb(1'b1, 12'hFD0, 32'h0, r);
    apb(1'b0, 12'hF00, 32'h0, r);
    chk("R11 test ctl kept", r, 32'h1);
    apb(1'b0, 12'hFD0, 32'h0, r);
    chk("R10 ident unchanged after write", r, 32'h04);

    apb(1'b1, 12'hF00, 32'hFFFFFFFE, r);
    apb(1'b0, 12'hF00, 32'h0, r);
    chk("R5 bit0 clears mode", r, 32'h0);
    settle();
    chk("R8 back to mis", {30'd0, irq}, 32'h1);

    // R12: reset clears test regs mid-run
    apb(1'b1, 12'hF04, 32'h3, r);
    apb(1'b1, 12'hF00, 32'h1, r);
    ch_mis = 2'b00;
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R12 irq cleared", {30'd0, irq}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    apb(1'b0, 12'hF00, 32'h0, r);
    chk("R12 test ctl cleared", r, 32'h0);
    apb(1'b1, 12'hF00, 32'h1, r);
    settle();
    chk("R12 test out cleared", {30'd0, irq}, 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule